// File: doc/BRIEF.md
# Line Clamp Window Generator

This block produces one clamp strobe per video line, timed in pixel clocks from the trailing edge of horizontal sync. It is used ahead of an analog front end. The strobe drives the DC-restore clamp, and it also marks the pixels over which black level is measured. The start offset and the pulse width are programmable. A start offset large enough to skip the whole active region places the window on the front porch instead of the back porch.

Horizontal sync has a programmable active level. The 16-bit start offset arrives as two bytes. The clamp is issued only when the input is AC-coupled. A gating control can forbid clamping while the pixel PLL coasts. All configuration is captured at the sync trailing edge, so a line's window cannot change partway through.

Top module: `line_clamp_gen`

## Requirements
- R1: From reset, and until the first HSYNC trailing edge, `clamp` is low.
- R2: A trailing edge is a move of `hsync` from its active level to its inactive level. The active level is high when `hs_pol`=1 and low when `hs_pol`=0. The edge is seen at the first rising clock edge that samples the inactive level.
- R3: Let S = {`start_hi`,`start_lo`}, captured at the trailing-edge clock edge (edge 0). `clamp` first goes high right after edge S. When S=0 it goes high right after edge 0.
- R4: Let W be `width`, captured at the trailing edge. `clamp` then stays high for exactly W consecutive cycles. W=0 gives no pulse on that line.
- R5: If `ac_couple` is 0 when captured at the trailing edge, `clamp` stays low for that whole line (1 = AC-coupled).
- R6: If `coast_gate_off` is 0 when captured at the trailing edge and `coast` is 1 at that edge, no clamp is issued on that line.
- R7: If `coast` is 1 during a pending or active window while the captured `coast_gate_off` is 0, `clamp` is low in that same cycle. It stays low for the rest of the line.
- R8: If the captured `coast_gate_off` is 1, `coast` has no effect on `clamp`.
- R9: A new trailing edge restarts the timing from R3. Any clamp pulse in progress ends at that edge.
- R10: Changes to `start_hi`, `start_lo`, `width`, `ac_couple` and `coast_gate_off` have no effect until the next trailing edge.
- R11: Start offsets up to 65535 are honoured in full, which lets the window fall after the active pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync |
| hs_pol | input | 1 | Sync active level: 1 = high, 0 = low |
| coast | input | 1 | PLL coast indicator |
| ac_couple | input | 1 | 1 = AC-coupled (clamp allowed), 0 = DC-coupled |
| coast_gate_off | input | 1 | 1 = clamp allowed while coasting, 0 = clamp suppressed by coast |
| start_hi | input | 8 | Upper byte of the start offset |
| start_lo | input | 8 | Lower byte of the start offset |
| width | input | 8 | Clamp width in pixels |
| clamp | output | 1 | Clamp / black-level-measurement strobe |

## Verification
Most internal errors reach `clamp` within one line. A counter that loads or ends one value off shifts the rising or falling cycle of the pulse by one, so a check on every cycle catches it at once. A wrong captured flag shows up only as a missing pulse or an extra pulse. For that reason, the scenarios change configuration and coast in the middle of lines, then compare the next line against what the flags captured at its edge should give. Fault in edge detection shows as a clamp tied to the wrong sync polarity from the first line on.

// File: rtl/line_clamp_gen.sv
module line_clamp_gen #(
  parameter int START_W = 16,
  parameter int WIDTH_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hsync,
  input  logic                       hs_pol,
  input  logic                       coast,
  input  logic                       ac_couple,
  input  logic                       coast_gate_off,
  input  logic [START_W-START_W/2-1:0] start_hi,
  input  logic [START_W/2-1:0]       start_lo,
  input  logic [WIDTH_W-1:0]         width,
  output logic                       clamp
);
  localparam int CNT_W = (START_W > WIDTH_W) ? START_W : WIDTH_W;

  typedef enum logic [1:0] {IDLE, WAIT, HOLD} st_t;

  st_t                st;
  logic [CNT_W-1:0]   cnt;
  logic               sync_d, cfg_ac, cfg_allow;
  logic [WIDTH_W-1:0] cfg_w;

  wire               sync_on   = hs_pol ? hsync : ~hsync;
  wire               trail     = sync_d & ~sync_on;
  wire [START_W-1:0] start_val = {start_hi, start_lo};
  wire               gate_now  = coast & ~cfg_allow;
  wire               refuse    = ~ac_couple | (coast & ~coast_gate_off) | (width == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d    <= 1'b0;
      st        <= IDLE;
      cnt       <= '0;
      cfg_ac    <= 1'b0;
      cfg_allow <= 1'b0;
      cfg_w     <= '0;
    end else begin
      sync_d <= sync_on;
      if (trail) begin
        cfg_ac    <= ac_couple;
        cfg_allow <= coast_gate_off;
        cfg_w     <= width;
        if (refuse) begin
          st <= IDLE;
        end else if (start_val == '0) begin
          st  <= HOLD;
          cnt <= CNT_W'(width);
        end else begin
          st  <= WAIT;
          cnt <= CNT_W'(start_val);
        end
      end else begin
        case (st)
          WAIT: begin
            if (gate_now) st <= IDLE;
            else if (cnt == CNT_W'(1)) begin
              st  <= HOLD;
              cnt <= CNT_W'(cfg_w);
            end else cnt <= cnt - 1'b1;
          end
          HOLD: begin
            if (gate_now || cnt == CNT_W'(1)) st <= IDLE;
            else cnt <= cnt - 1'b1;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  assign clamp = (st == HOLD) & cfg_ac & ~gate_now;
endmodule

module line_clamp_chk #(
  parameter int START_W = 16,
  parameter int WIDTH_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hsync,
  input logic                       hs_pol,
  input logic                       coast,
  input logic                       ac_couple,
  input logic                       coast_gate_off,
  input logic [START_W-START_W/2-1:0] start_hi,
  input logic [START_W/2-1:0]       start_lo,
  input logic [WIDTH_W-1:0]         width,
  input logic                       clamp
);
  logic        prev_on, allow_c, seen_c;
  logic [15:0] run_c;
  logic [WIDTH_W-1:0] wid_c;
  wire on_c    = hs_pol ? hsync : ~hsync;
  wire trail_c = prev_on & ~on_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_on <= 1'b0;
      allow_c <= 1'b0;
      seen_c  <= 1'b0;
      run_c   <= '0;
      wid_c   <= '0;
    end else begin
      prev_on <= on_c;
      if (trail_c) begin
        allow_c <= coast_gate_off;
        wid_c   <= width;
        seen_c  <= 1'b1;
        run_c   <= '0;
      end else if (clamp && run_c != 16'hFFFF) run_c <= run_c + 1'b1;
    end
  end

  a_r1_quiet_before_edge: assert property (@(posedge clk) disable iff (!rst_n) !seen_c |-> !clamp);
  a_r3_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_c && {start_hi, start_lo} != '0) |=> !clamp);
  a_r4_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> (32'(run_c) < 32'(wid_c)));
  a_r4_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_c && width == '0) |=> !clamp);
  a_r5_dc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_c && !ac_couple) |=> !clamp);
  a_r7_coast_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (coast && !allow_c) |-> !clamp);
endmodule

bind line_clamp_gen line_clamp_chk #(.START_W(START_W), .WIDTH_W(WIDTH_W)) u_chk (.*);

// File: tb/sim_line_clamp_gen.sv
`timescale 1ns/1ps
module sim_line_clamp_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync = 1'b0, hs_pol = 1'b1, coast = 1'b0, ac_couple = 1'b1, coast_gate_off = 1'b0;
  logic [7:0] start_hi = 8'd0, start_lo = 8'd10, width = 8'd5;
  logic clamp;
  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  line_clamp_gen u0 (.clk(clk), .rst_n(rst_n), .hsync(hsync), .hs_pol(hs_pol), .coast(coast),
    .ac_couple(ac_couple), .coast_gate_off(coast_gate_off), .start_hi(start_hi),
    .start_lo(start_lo), .width(width), .clamp(clamp));

  // behavioural reference: k = edges since the last trailing edge
  bit prev_on = 0, valid = 0, killed = 0, m_ac = 0, m_allow = 0;
  int k = 0, m_s = 0, m_w = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      prev_on = 0; valid = 0; killed = 0;
    end else begin
      bit on_now;
      on_now = hs_pol ? hsync : !hsync;
      if (prev_on && !on_now) begin
        valid = 1; k = 0;
        m_s = {start_hi, start_lo}; m_w = width;
        m_ac = ac_couple; m_allow = coast_gate_off;
        killed = coast && !coast_gate_off;
      end else if (valid) begin
        if (coast && !m_allow) killed = 1;
        k++;
      end
      prev_on = on_now;
    end
  end

  function automatic bit expect_clamp();
    if (!rst_n || !valid || killed || !m_ac) return 0;
    if (coast && !m_allow) return 0;
    return (k >= m_s) && (k < m_s + m_w);
  endfunction

  task automatic tick();
    bit e;
    @(negedge clk);
    e = expect_clamp();
    checks++;
    if (clamp !== e) begin
      errors++;
      $display("FAIL %s cycle %0d: clamp=%b expected=%b", cur_req, cycles, clamp, e);
    end
  endtask

  task automatic set_sync(bit active);
    hsync = hs_pol ? active : !active;
  endtask

  // act cycles of sync, then idle cycles; coast raised at idle index coast_at; config change at chg_at
  task automatic run_line(int act, int idle, int coast_at, int chg_at);
    set_sync(1);
    for (int i = 0; i < act; i++) tick();
    set_sync(0);
    for (int i = 0; i < idle; i++) begin
      tick();
      if (i == coast_at) coast = 1;
      if (i == chg_at) begin
        width = width + 8'd7; start_lo = start_lo + 8'd3; ac_couple = !ac_couple;
        coast_gate_off = !coast_gate_off;
      end
    end
    coast = 0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin cur_req = "R1"; tick(); end
    rst_n = 1;
    for (int i = 0; i < 6; i++) begin cur_req = "R1"; tick(); end
    cur_req = "R3"; start_lo = 8'd10; width = 8'd5;
    run_line(8, 40, -1, -1);
    run_line(8, 40, -1, -1);
    cur_req = "R3"; start_lo = 8'd0; width = 8'd3;
    run_line(5, 20, -1, -1);
    cur_req = "R3"; start_lo = 8'd1; width = 8'd1;
    run_line(5, 20, -1, -1);
    cur_req = "R4"; start_lo = 8'd4; width = 8'd255;
    run_line(5, 300, -1, -1);
    cur_req = "R4"; width = 8'd0;
    run_line(5, 30, -1, -1);
    cur_req = "R2"; hs_pol = 1'b0; hsync = 1'b1; width = 8'd6; start_lo = 8'd5;
    for (int i = 0; i < 3; i++) tick();
    run_line(7, 30, -1, -1);
    run_line(7, 30, -1, -1);
    hs_pol = 1'b1; hsync = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    cur_req = "R5"; ac_couple = 1'b0;
    run_line(5, 30, -1, -1);
    ac_couple = 1'b1;
    cur_req = "R6"; coast = 1'b1;
    run_line(5, 30, -1, -1);
    cur_req = "R7"; coast_gate_off = 1'b0; start_lo = 8'd5; width = 8'd20;
    run_line(5, 40, 10, -1);
    run_line(5, 40, 2, -1);
    cur_req = "R8"; coast_gate_off = 1'b1; coast = 1'b1;
    run_line(5, 40, 8, -1);
    coast_gate_off = 1'b0;
    cur_req = "R9"; start_lo = 8'd3; width = 8'd50;
    run_line(4, 10, -1, -1);
    run_line(4, 30, -1, -1);
    run_line(4, 70, -1, -1);
    cur_req = "R10"; start_lo = 8'd4; width = 8'd10;
    run_line(4, 30, 0 - 1, 6);
    run_line(4, 30, -1, 8);
    run_line(4, 30, -1, 2);
    ac_couple = 1'b1; coast_gate_off = 1'b0;
    cur_req = "R11"; start_hi = 8'h0B; start_lo = 8'hB8; width = 8'd12;
    run_line(10, 3100, -1, -1);
    cur_req = "R11"; start_hi = 8'hFF; start_lo = 8'hFF; width = 8'd4;
    run_line(10, 65560, -1, -1);
    finish_up();
  end

  task automatic finish_up();
    if (done) return;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_up();
  end
endmodule